// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a link to a small successive-approximation converter that has an 8-bit serial output. It makes the serial clock from the system clock through a programmable half-period divider. It drives an active-low chip select and an active-low output enable. It also presents a single select line, which carries the converter's input-mode or channel choice, and holds it for the whole frame. The converter shifts four zero bits and then eight result bits, MSB first, on falling clock edges. The reader samples the data line on rising edges, drops the leading bits and returns the byte with a one-cycle valid strobe. Alongside the byte it returns a format flag that tells the consumer whether the byte is straight binary or two's complement.

Two kinds of framing are supported. A single-shot read is started by `start` and lasts 12 or 16 clocks, chosen per frame. During a single-shot read the output enable moves together with chip select. While `cont_en` is high the reader runs back to back in frame-sync style. In that mode the output enable stays low, every frame is 16 clocks long, and chip select acts as a short frame-sync pulse. That pulse falls in the same system cycle as the 16th falling clock edge of the previous frame.

Top module: `adc_frame_reader`

## Requirements
- R1: After a synchronous active-low reset, `cs_n` and `oe_n` are high, `sclk` is low and `result_valid` is low.
- R2: Both the high phase and the low phase of `sclk` last H system cycles, where H = max(`half_div`+1, MIN_HALF). MIN_HALF defaults to 9, which gives at least 90 ns at 100 MHz.
- R3: `sel_out` and the format flag are latched from `chan_sel` and `bipolar_sel` in the cycle in which `cs_n` falls. They do not change for the rest of the frame. The first rising edge of `sclk` comes exactly H cycles after `cs_n` falls.
- R4: `sdi` is sampled on each rising edge of `sclk`. The samples from rising edges 1 to 4 are discarded. The samples from rising edges 5 to 12 form `result`, with the sample from edge 5 as bit 7. `result_valid` is high for one cycle, which is the cycle in which `sclk` rises for the 12th time.
- R5: A single-shot frame has 16 clock pulses when `frame_long`=1 and 12 when `frame_long`=0. The value is sampled at frame start. `cs_n` rises in the same cycle as the last falling edge of `sclk`.
- R6: In single-shot operation `oe_n` equals `cs_n` at all times. A `start` that arrives while a frame is in progress is ignored. Between two frames, `cs_n` stays high for at least H cycles.
- R7: While `cont_en` is high, frames are 16 clocks long whatever `frame_long` is. `oe_n` stays low between frames. `cs_n` rises with the 16th rising edge and falls in the same cycle as the 16th falling edge. The next frame's first rising edge follows H cycles later.
- R8: If `cont_en` is low at the 16th falling edge of a continuous frame, `cs_n` and `oe_n` both end high and no further frame starts.
- R9: `result_bipolar` equals the `bipolar_sel` value latched at the start of the frame that produced `result` (1 = two's complement, 0 = straight binary). It changes only together with `result_valid`.
- R10: Values on `sdi` during rising edges 1 to 4 have no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Requests one single-shot frame when the reader is idle |
| cont_en | input | 1 | Runs continuous frame-sync conversions while high |
| frame_long | input | 1 | Single-shot frame length: 1 = 16 clocks, 0 = 12 clocks |
| bipolar_sel | input | 1 | Format to tag the result with: 1 = two's complement |
| chan_sel | input | 1 | Mode or channel value to present on `sel_out` |
| half_div | input | DIV_W | Half-period of `sclk` in system cycles, minus one |
| sdi | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select / frame sync |
| oe_n | output | 1 | Active-low output enable for the converter |
| sel_out | output | 1 | Mode or channel select held for the frame |
| result | output | DATA_W | Last captured conversion |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |
| result_bipolar | output | 1 | Format flag belonging to `result` |

## Verification
The hardest point to reach is the hand-over between two continuous frames. At that point `cs_n` must fall in the very cycle that `sclk` falls for the 16th time, and `oe_n` must stay low the whole time. The point only exists when `cont_en` is still high at the end of one frame and drops before the end of the next. The bench therefore holds `cont_en` high from idle and releases it right after the third result strobe. A behavioural converter model reloads its bit counter on every `cs_n` fall, so a misplaced frame sync shows up as a wrong byte. The model can also drive ones into the leading bits, which shows whether the reader really discards them.

// File: rtl/adcrd_pkg.sv
// Shared definitions for the serial ADC frame reader.
package adcrd_pkg;
    // Sequencer states: idle, chip-select setup, clock high, clock low, and the
    // chip-select-high gap that follows a frame.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_HIGH  = 3'd2,
        ST_LOW   = 3'd3,
        ST_GAP   = 3'd4
    } rd_state_t;
endpackage

// File: rtl/adcrd_half_timer.sv
// Half-period timer for the serial clock.
// What it does: while `run` is high it pulses `tick` once every H cycles, with
//   H = max(half_div+1, MIN_HALF). The count restarts from zero whenever run
//   has been low.
// Assumes: half_div is static for the duration of a frame.
module adcrd_half_timer #(
    parameter int DIV_W    = 8,
    parameter int MIN_HALF = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_HALF - 1);

    logic [DIV_W-1:0] limit;
    logic [DIV_W-1:0] cnt;

    // Raise a too-short programmed half-period to the timing floor.
    always_comb limit = (half_div < FLOOR) ? FLOOR : half_div;

    assign tick = run && (cnt >= limit);

    // Count system cycles within the current half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || cnt >= limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adcrd_seq.sv
// Frame sequencer.
// What it does: drives sclk, cs_n and oe_n through setup, clock pulses and
//   gap. It numbers the rising edges and flags frame starts (frame_go) and
//   rising edges (rise_go) in the cycle before they show on the pins.
// Assumes: tick comes from a half-period timer that runs whenever `run` is high.
module adcrd_seq
    import adcrd_pkg::*;
#(
    parameter int LEAD     = 4,
    parameter int DATA_W   = 8,
    parameter int LONG_LEN = 16,
    parameter int EW       = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cont_en,
    input  logic          frame_long,
    input  logic          tick,
    output logic          run,
    output logic          sclk,
    output logic          cs_n,
    output logic          oe_n,
    output logic          frame_go,
    output logic          rise_go,
    output logic [EW-1:0] rise_idx
);
    localparam int SHORT_LEN = LEAD + DATA_W;

    rd_state_t     state;
    logic [EW-1:0] edge_cnt;
    logic [EW-1:0] last_edge;
    logic          cont_q;
    logic          long_q;
    logic          at_last;
    logic          relaunch;

    assign last_edge = long_q ? EW'(LONG_LEN) : EW'(SHORT_LEN);
    assign at_last   = (edge_cnt == last_edge);
    assign relaunch  = (state == ST_HIGH) && tick && at_last && cont_q && cont_en;
    assign frame_go  = ((state == ST_IDLE) && (start || cont_en)) || relaunch;
    assign rise_go   = tick && ((state == ST_SETUP) || (state == ST_LOW));
    assign rise_idx  = edge_cnt + EW'(1);
    assign run       = (state != ST_IDLE);

    // Step through the frame and drive the link pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sclk     <= 1'b0;
            cs_n     <= 1'b1;
            oe_n     <= 1'b1;
            edge_cnt <= '0;
            cont_q   <= 1'b0;
            long_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start || cont_en) begin
                        state    <= ST_SETUP;
                        cs_n     <= 1'b0;
                        oe_n     <= 1'b0;
                        edge_cnt <= '0;
                        cont_q   <= cont_en;
                        long_q   <= cont_en | frame_long;
                    end
                end
                ST_SETUP, ST_LOW: begin
                    if (tick) begin
                        sclk     <= 1'b1;
                        edge_cnt <= rise_idx;
                        state    <= ST_HIGH;
                        if (cont_q && rise_idx == EW'(LONG_LEN)) begin
                            cs_n <= 1'b1;
                        end
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sclk <= 1'b0;
                        if (!at_last) begin
                            state <= ST_LOW;
                        end else if (relaunch) begin
                            cs_n     <= 1'b0;
                            edge_cnt <= '0;
                            state    <= ST_SETUP;
                        end else begin
                            cs_n  <= 1'b1;
                            oe_n  <= 1'b1;
                            state <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adcrd_capture.sv
// Result capture.
// What it does: on the rising edges numbered LEAD+1 .. LEAD+DATA_W it shifts
//   sdi in MSB first. On the last of those edges it loads the result and its
//   format flag and raises a one-cycle valid.
// Assumes: sdi is stable around the rising edge. The converter changes it half
//   a serial period earlier.
module adcrd_capture #(
    parameter int LEAD   = 4,
    parameter int DATA_W = 8,
    parameter int EW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_go,
    input  logic [EW-1:0]     rise_idx,
    input  logic              sdi,
    input  logic              fmt_in,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic              result_fmt
);
    localparam int FIRST = LEAD + 1;
    localparam int LAST  = LEAD + DATA_W;

    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] shifted;
    logic              in_window;
    logic              at_lsb;

    assign shifted   = {shreg[DATA_W-2:0], sdi};
    assign in_window = rise_go && (rise_idx >= EW'(FIRST)) && (rise_idx <= EW'(LAST));
    assign at_lsb    = rise_go && (rise_idx == EW'(LAST));

    // Shift data bits and publish the byte when the last one arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg        <= '0;
            result       <= '0;
            result_valid <= 1'b0;
            result_fmt   <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            if (in_window) begin
                shreg <= shifted;
            end
            if (at_lsb) begin
                result       <= shifted;
                result_fmt   <= fmt_in;
                result_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_frame_reader.sv
// Serial ADC frame reader (top).
// What it does: ties the half-period timer, the frame sequencer and the result
//   capture together. It latches the select and format inputs at every frame
//   start.
// Assumes: LONG_LEN >= LEAD_BITS + DATA_W, and the converter changes sdi on
//   falling sclk edges.
module adc_frame_reader #(
    parameter int DATA_W    = 8,
    parameter int LEAD_BITS = 4,
    parameter int LONG_LEN  = 16,
    parameter int DIV_W     = 8,
    parameter int MIN_HALF  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cont_en,
    input  logic              frame_long,
    input  logic              bipolar_sel,
    input  logic              chan_sel,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              sdi,
    output logic              sclk,
    output logic              cs_n,
    output logic              oe_n,
    output logic              sel_out,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic              result_bipolar
);
    localparam int EW = $clog2(LONG_LEN + 1);

    logic          run;
    logic          tick;
    logic          frame_go;
    logic          rise_go;
    logic [EW-1:0] rise_idx;
    logic          fmt_q;

    adcrd_half_timer #(
        .DIV_W    (DIV_W),
        .MIN_HALF (MIN_HALF)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_div (half_div),
        .tick     (tick)
    );

    adcrd_seq #(
        .LEAD     (LEAD_BITS),
        .DATA_W   (DATA_W),
        .LONG_LEN (LONG_LEN),
        .EW       (EW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cont_en    (cont_en),
        .frame_long (frame_long),
        .tick       (tick),
        .run        (run),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .oe_n       (oe_n),
        .frame_go   (frame_go),
        .rise_go    (rise_go),
        .rise_idx   (rise_idx)
    );

    // Hold the select and format choices from frame start to frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_out <= 1'b0;
            fmt_q   <= 1'b0;
        end else if (frame_go) begin
            sel_out <= chan_sel;
            fmt_q   <= bipolar_sel;
        end
    end

    adcrd_capture #(
        .LEAD   (LEAD_BITS),
        .DATA_W (DATA_W),
        .EW     (EW)
    ) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .rise_go      (rise_go),
        .rise_idx     (rise_idx),
        .sdi          (sdi),
        .fmt_in       (fmt_q),
        .result       (result),
        .result_valid (result_valid),
        .result_fmt   (result_bipolar)
    );
endmodule

// File: rtl/adcrd_checker.sv
// Protocol checker for adc_frame_reader, attached with bind.
// What it does: watches the link pins and the result port for timing and
// framing rules.
module adcrd_checker #(
    parameter int MIN_HALF = 9
) (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic cs_n,
    input logic oe_n,
    input logic sel_out,
    input logic result_valid,
    input logic result_bipolar
);
    logic [15:0] hi_cnt;

    // Count the cycles of the current sclk high phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !sclk) begin
            hi_cnt <= '0;
        end else if (hi_cnt != 16'hFFFF) begin
            hi_cnt <= hi_cnt + 16'd1;
        end
    end

    // R1/R5: no clock pulses while the converter output is disabled.
    p_no_clock_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !sclk);

    // R6/R7: chip select is only ever low while output enable is low.
    p_cs_inside_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !oe_n);

    // R2: every high phase lasts at least the floor.
    p_high_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_cnt >= 16'(MIN_HALF)));

    // R3: select changes only as a frame starts.
    p_sel_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_out) |-> $fell(cs_n));

    // R4: valid is a single-cycle strobe.
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R4: valid coincides with a rising serial clock edge.
    p_valid_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $rose(sclk));

    // R9: the format flag moves only with a new result.
    p_fmt_with_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_bipolar) |-> result_valid);
endmodule

bind adc_frame_reader adcrd_checker #(
    .MIN_HALF (MIN_HALF)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sclk           (sclk),
    .cs_n           (cs_n),
    .oe_n           (oe_n),
    .sel_out        (sel_out),
    .result_valid   (result_valid),
    .result_bipolar (result_bipolar)
);

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       cont_en = 1'b0;
    logic       frame_long = 1'b0;
    logic       bipolar_sel = 1'b0;
    logic       chan_sel = 1'b0;
    logic [7:0] half_div = 8'd9;
    logic       sdi = 1'b0;
    logic       sclk, cs_n, oe_n, sel_out, result_valid, result_bipolar;
    logic [7:0] result;

    adc_frame_reader u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cont_en(cont_en),
        .frame_long(frame_long), .bipolar_sel(bipolar_sel), .chan_sel(chan_sel),
        .half_div(half_div), .sdi(sdi), .sclk(sclk), .cs_n(cs_n), .oe_n(oe_n),
        .sel_out(sel_out), .result(result), .result_valid(result_valid),
        .result_bipolar(result_bipolar)
    );

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor and behavioural converter state.
    logic [7:0] model_codes [0:31];
    int   model_rd = 0, model_wr = 0, fall_cnt = 0;
    logic [7:0] cur = 8'h00;
    bit   lead_fill = 1'b0;
    bit   single_mode = 1'b1;
    bit   prev_sclk = 1'b0, prev_cs = 1'b1, prev_oe = 1'b1;
    int   frames = 0, rises = 0, since_cs = 0, hi_len = 0;
    int   min_hi = 1000, max_hi = 0, first_setup = 0;
    int   cs_hi_len = 0, last_gap = 0, sync_co = 0, rises_at_csrise = 0;
    int   oe_bad = 0, oe_rises = 0, n_got = 0;
    int   last_res = 0, last_fmt = 0, last_sel = 0, last_rise = 0;

    // Observe the pins and act as the converter, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !cs_n) begin
                frames++;
                if (prev_sclk && !sclk) sync_co++;
                last_gap = cs_hi_len;
                rises = 0;
                since_cs = 0;
                cur = model_codes[model_rd[4:0]];
                model_rd++;
                fall_cnt = 0;
                sdi = lead_fill;
            end else begin
                since_cs++;
                if (prev_sclk && !sclk) begin
                    fall_cnt++;
                    if (fall_cnt < 4) sdi = lead_fill;
                    else if (fall_cnt <= 11) sdi = cur[11 - fall_cnt];
                    else sdi = 1'b0;
                end
            end
            if (!prev_sclk && sclk) begin
                rises++;
                if (rises == 1) first_setup = since_cs;
                // R4: the converter must present zeros in the leading bits
                if (rises <= 4 && !lead_fill)
                    check(sdi == 1'b0, "R4 leading bit zero", int'(sdi), 0);
            end
            if (!prev_cs && cs_n) rises_at_csrise = rises;
            if (sclk) hi_len++;
            else if (prev_sclk) begin
                if (hi_len < min_hi) min_hi = hi_len;
                if (hi_len > max_hi) max_hi = hi_len;
                hi_len = 0;
            end
            if (cs_n) cs_hi_len++;
            else cs_hi_len = 0;
            if (single_mode && (cs_n != oe_n)) oe_bad++;
            if (!prev_oe && oe_n) oe_rises++;
            if (result_valid) begin
                last_res  = int'(result);
                last_fmt  = int'(result_bipolar);
                last_sel  = int'(sel_out);
                last_rise = sclk ? rises : -1;
                n_got++;
            end
        end
        prev_sclk = sclk;
        prev_cs   = cs_n;
        prev_oe   = oe_n;
    end

    task automatic wait_got(input int target);
        int t = 0;
        while (n_got < target && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check(n_got >= target, "R4 result strobe seen", n_got, target);
    endtask

    task automatic push_code(input logic [7:0] c);
        model_codes[model_wr[4:0]] = c;
        model_wr++;
    endtask

    task automatic one_frame(input logic [7:0] c, input bit bip, input bit sel, input bit lng);
        int tgt;
        tgt = n_got + 1;
        push_code(c);
        @(negedge clk);
        bipolar_sel = bip;
        chan_sel = sel;
        frame_long = lng;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_got(tgt);
        repeat (400) @(negedge clk);
    endtask

    // Vector: code[10:3], bipolar[2], select[1], long frame[0]
    localparam logic [10:0] VEC [0:5] = '{
        {8'hA5, 1'b0, 1'b0, 1'b0},
        {8'h00, 1'b1, 1'b1, 1'b1},
        {8'hFF, 1'b1, 1'b0, 1'b0},
        {8'h80, 1'b0, 1'b1, 1'b1},
        {8'h7F, 1'b1, 1'b1, 1'b0},
        {8'h01, 1'b0, 1'b0, 1'b1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int f0, s0, o0, tgt;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cs_n && oe_n, "R1 cs_n/oe_n high in reset", int'({cs_n, oe_n}), 3);
        check(!sclk && !result_valid, "R1 sclk/valid low in reset", int'({sclk, result_valid}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(cs_n && oe_n && !sclk, "R1 idle after reset", int'({cs_n, oe_n, sclk}), 6);

        // Table-driven single-shot frames
        for (int i = 0; i < 6; i++) begin
            one_frame(VEC[i][10:3], VEC[i][2], VEC[i][1], VEC[i][0]);
            check(last_res == int'(VEC[i][10:3]), "R4 result byte", last_res, int'(VEC[i][10:3]));
            check(last_rise == 12, "R4 valid on 12th rise", last_rise, 12);
            check(last_fmt == int'(VEC[i][2]), "R9 format flag", last_fmt, int'(VEC[i][2]));
            check(last_sel == int'(VEC[i][1]), "R3 select output", last_sel, int'(VEC[i][1]));
            check(rises_at_csrise == (VEC[i][0] ? 16 : 12), "R5 clocks per frame",
                  rises_at_csrise, VEC[i][0] ? 16 : 12);
            check(first_setup == 10, "R3 cs fall to first rise", first_setup, 10);
        end
        check(oe_bad == 0, "R6 oe_n follows cs_n", oe_bad, 0);
        check(min_hi == 10 && max_hi == 10, "R2 high phase at half_div=9", min_hi, 10);

        // R2: floor clamp and a longer divider
        min_hi = 1000; max_hi = 0;
        half_div = 8'd2;
        one_frame(8'h5A, 1'b0, 1'b0, 1'b0);
        check(min_hi == 9 && max_hi == 9, "R2 floor clamp high phase", min_hi, 9);
        check(first_setup == 9, "R2 floor clamp setup", first_setup, 9);
        check(last_res == 8'h5A, "R4 result at floor rate", last_res, 8'h5A);
        min_hi = 1000; max_hi = 0;
        half_div = 8'd11;
        one_frame(8'hC3, 1'b1, 1'b1, 1'b1);
        check(min_hi == 12 && max_hi == 12, "R2 high phase at half_div=11", max_hi, 12);
        check(last_res == 8'hC3, "R4 result at slow rate", last_res, 8'hC3);
        half_div = 8'd9;

        // R6: start during a frame is ignored
        f0 = frames;
        tgt = n_got + 1;
        push_code(8'h96);
        @(negedge clk); frame_long = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (60) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_got(tgt);
        repeat (400) @(negedge clk);
        check(frames - f0 == 1, "R6 start ignored mid-frame", frames - f0, 1);
        check(last_res == 8'h96, "R6 result unaffected", last_res, 8'h96);

        // R6: held start gives back-to-back frames with a cs-high gap
        f0 = frames;
        tgt = n_got + 2;
        push_code(8'h3E);
        push_code(8'hE1);
        @(negedge clk); start = 1'b1;
        wait_got(tgt);
        start = 1'b0;
        repeat (400) @(negedge clk);
        check(frames - f0 == 2, "R6 two frames while start held", frames - f0, 2);
        check(last_gap >= 10, "R6 cs high gap", last_gap, 10);
        check(last_res == 8'hE1, "R4 second back-to-back result", last_res, 8'hE1);

        // R3/R9: inputs changed mid-frame do not reach the outputs
        tgt = n_got + 1;
        push_code(8'h4B);
        @(negedge clk); bipolar_sel = 1'b1; chan_sel = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        bipolar_sel = 1'b0; chan_sel = 1'b0;
        wait_got(tgt);
        repeat (400) @(negedge clk);
        check(last_fmt == 1, "R9 format latched at frame start", last_fmt, 1);
        check(last_sel == 1, "R3 select latched at frame start", last_sel, 1);

        // R10: ones in the leading bits are discarded
        lead_fill = 1'b1;
        one_frame(8'h3C, 1'b0, 1'b0, 1'b1);
        lead_fill = 1'b0;
        check(last_res == 8'h3C, "R10 leading ones ignored", last_res, 8'h3C);

        // R7/R8: continuous frame-sync run of three frames
        f0 = frames; s0 = sync_co; o0 = oe_rises;
        push_code(8'h11);
        push_code(8'h9E);
        push_code(8'h62);
        tgt = n_got + 1;
        @(negedge clk); single_mode = 1'b0; frame_long = 1'b0; cont_en = 1'b1;
        wait_got(tgt);
        check(last_res == 8'h11, "R7 continuous frame 1", last_res, 8'h11);
        wait_got(tgt + 1);
        check(last_res == 8'h9E, "R7 continuous frame 2", last_res, 8'h9E);
        check(first_setup == 10, "R7 rise a half-period after sync", first_setup, 10);
        wait_got(tgt + 2);
        cont_en = 1'b0;
        check(last_res == 8'h62, "R7 continuous frame 3", last_res, 8'h62);
        repeat (400) @(negedge clk);
        check(sync_co - s0 == 2, "R7 sync fall with 16th falling edge", sync_co - s0, 2);
        check(oe_rises - o0 == 1, "R7 oe_n held low across frames", oe_rises - o0, 1);
        check(rises_at_csrise == 16, "R7 16 clocks in continuous mode", rises_at_csrise, 16);
        check(frames - f0 == 3, "R8 stops after cont_en drops", frames - f0, 3);
        check(cs_n && oe_n && !sclk, "R8 idle after continuous run", int'({cs_n, oe_n, sclk}), 6);
        single_mode = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule